// File: doc/BRIEF.md
# SPI Target Port with Double-Buffered Transmit

This block lets a chip act as the target (slave) side of an SPI link. The external controller drives SCK, MOSI and, optionally, an active-low select. The block drives MISO. All three incoming pins are first resynchronised into the system clock domain. SCK transitions are then found by comparing successive samples. The system clock must run at least four times faster than SCK. The clocking is fixed to SPI mode 0: MOSI is captured on SCK rising edges, MISO moves on falling edges, and bytes travel MSB first. The target never starts a transfer; every bit is paced by the controller.

On the host side there is a write strobe that deposits a byte into a one-entry holding register ahead of the transmit shifter. A separate read port always shows the last completed received byte. A completion flag is raised for every finished byte and stays up until the host pulses a clear strobe. A two-bit mode input picks between two wiring options. In four-wire operation the select pin gates the block and resets its bit counter. In three-wire operation select plays no part, and only the enable input can realign the bit counter.

Top module: `spi_target_port`

## Requirements
- R1: After eight SCK rising edges while the port is active, `rd_data` holds the eight MOSI bits (first bit in bit 7) and `done_flag` is 1, at the latest on the third system clock edge after the eighth rising edge reaches the pin.
- R2: Transmit bytes go out MSB first. Bit 7 is on MISO before the first SCK rising edge of a byte, and each following bit appears after an SCK falling edge.
- R3: A host write made while the shifter holds no unsent byte and no byte is in progress (bit count zero) moves to the shifter at once. Its bit 7 is on MISO by the second clock edge after the strobe.
- R4: A host write made at any other time waits in the holding register and enters the shifter on the eighth SCK rising edge of the current byte. A later write before that moment replaces the waiting byte.
- R5: A byte that starts with no unsent data in the shifter transmits all zeros.
- R6: With `mode` = 01 (four-wire), while `sel_n_pin` is 1 SCK edges have no effect on the bit count, `rd_data` or `done_flag`, and MISO is 0.
- R7: In four-wire mode a falling edge of `sel_n_pin` resets the bit count to zero and discards any partial byte.
- R8: With `mode` at any value other than 01 (three-wire), `sel_n_pin` is ignored: transfers run with it high, and toggling it does not reset the bit count.
- R9: While `en` is 0 the bit count is held at zero, SCK is ignored and MISO is 0. After `en` returns to 1, counting restarts at the first bit.
- R10: `done_flag` stays 1 until a `clr_stb` pulse, and a byte completing in the same cycle as the clear wins. `rd_data` changes only when a byte completes.
- R11: After reset `rd_data` is 0, `done_flag` is 0, MISO is 0 and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low clears the bit count and silences MISO |
| mode | input | 2 | 01 = four-wire with select, other values = three-wire |
| sck_pin | input | 1 | Serial clock from the controller |
| mosi_pin | input | 1 | Serial data from the controller |
| sel_n_pin | input | 1 | Active-low select (four-wire only) |
| miso_pin | output | 1 | Serial data to the controller, 0 when inactive |
| wr_stb | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | DATA_W | Host transmit byte |
| rd_data | output | DATA_W | Last completed received byte |
| done_flag | output | 1 | Byte-complete flag |
| clr_stb | input | 1 | Host clear strobe for `done_flag` |

## Verification
Each pin event reaches its result after the two synchronizer stages plus one edge-detect register. A received byte and its flag are therefore due on the third clock after the eighth SCK rise. A MISO change is due three clocks after an SCK fall, and a shifter load two clocks after a write strobe. The bench holds each SCK level for eight system clocks and reads MISO just before it raises SCK. It reads `rd_data` and `done_flag` at least four clocks after the final edge of a byte, and it spaces host writes four clocks apart, so that every sample falls after the due cycle. Expected transmit bytes come from a small holding/shifter model in the bench that applies R3 to R5 at byte boundaries.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  localparam logic [1:0] MODE_FOUR_WIRE = 2'b01;

  // Four-wire is one exact code; every other code means three-wire.
  function automatic logic is_four_wire(input logic [1:0] m);
    return m == MODE_FOUR_WIRE;
  endfunction

  // True when the bit position about to be sampled is the final one of a word.
  function automatic logic is_last_bit(input int unsigned cnt, input int unsigned width);
    return cnt == width - 1;
  endfunction

  // Bit count after one sampled bit, wrapping at the word width.
  function automatic int unsigned count_after(input int unsigned cnt, input int unsigned width);
    return (cnt == width - 1) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge #(
  parameter bit   DETECT_RISE = 1'b1,
  parameter logic RST_VAL     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign pulse = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse = ~lvl & prev_q;
    end
  endgenerate

endmodule

// File: rtl/spi_tgt_rxpath.sv
module spi_tgt_rxpath
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              bit_in,
  input  logic              cnt_clr,
  input  logic              clr_stb,
  output logic              byte_done,
  output logic              bit_idle,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] rx_buf,
  output logic              done_flag
);

  logic [DATA_W-2:0] part_q;
  logic [DATA_W-1:0] part_next;

  assign part_next = {part_q, bit_in};
  assign byte_done = sample && is_last_bit(32'(bit_cnt), DATA_W);
  assign bit_idle  = (bit_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      part_q  <= '0;
    end else if (cnt_clr) begin
      bit_cnt <= '0;
      part_q  <= '0;
    end else if (sample) begin
      bit_cnt <= CNT_W'(count_after(32'(bit_cnt), DATA_W));
      part_q  <= part_next[DATA_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
    end else if (byte_done) begin
      rx_buf <= part_next;
    end
  end

  // Completion has priority over the host clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_flag <= 1'b0;
    else if (byte_done) done_flag <= 1'b1;
    else if (clr_stb)   done_flag <= 1'b0;
  end

endmodule

// File: rtl/spi_tgt_txpath.sv
module spi_tgt_txpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              shift,
  input  logic              byte_done,
  input  logic              bit_idle,
  output logic              tx_bit
);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic [DATA_W-1:0] sh_q;
  logic              sh_loaded;
  logic              move_now;

  // Shifter counts as empty only with no unsent byte and no word in flight.
  assign move_now = hold_full && !sh_loaded && bit_idle && !byte_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      sh_loaded <= 1'b0;
    end else begin
      if (byte_done) begin
        if (hold_full) begin
          sh_q      <= hold_q;
          sh_loaded <= 1'b1;
          hold_full <= 1'b0;
        end else begin
          sh_q      <= '0;
          sh_loaded <= 1'b0;
        end
      end else if (move_now) begin
        sh_q      <= hold_q;
        sh_loaded <= 1'b1;
        hold_full <= 1'b0;
      end else if (shift) begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
      // A fresh write always lands in the holding register last.
      if (wr_stb) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  assign tx_bit = sh_q[DATA_W-1];

endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
  import spi_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              sck_pin,
  input  logic              mosi_pin,
  input  logic              sel_n_pin,
  output logic              miso_pin,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              done_flag,
  input  logic              clr_stb
);

  logic             sck_s, mosi_s, sel_s;
  logic             sck_rise, sck_fall, sel_fall;
  logic             four_wire, active, cnt_clr;
  logic             sample, shift;
  logic             byte_done, bit_idle, tx_bit;
  logic [CNT_W-1:0] bit_cnt;
  logic             sel_idle;

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck_pin, mosi_pin, sel_n_pin}),
    .q    ({sck_s, mosi_s, sel_s})
  );

  spi_tgt_edge #(.DETECT_RISE(1'b1), .RST_VAL(1'b0)) u_sck_up (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .pulse(sck_rise)
  );

  spi_tgt_edge #(.DETECT_RISE(1'b0), .RST_VAL(1'b0)) u_sck_dn (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .pulse(sck_fall)
  );

  spi_tgt_edge #(.DETECT_RISE(1'b0), .RST_VAL(1'b1)) u_sel_dn (
    .clk(clk), .rst_n(rst_n), .lvl(sel_s), .pulse(sel_fall)
  );

  assign four_wire = is_four_wire(mode);
  assign active    = en && (!four_wire || !sel_s);
  assign cnt_clr   = !en || (four_wire && sel_fall);
  assign sample    = active && sck_rise;
  assign shift     = active && sck_fall && !bit_idle;
  assign sel_idle  = en && four_wire && sel_s;

  spi_tgt_rxpath #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (sample),
    .bit_in   (mosi_s),
    .cnt_clr  (cnt_clr),
    .clr_stb  (clr_stb),
    .byte_done(byte_done),
    .bit_idle (bit_idle),
    .bit_cnt  (bit_cnt),
    .rx_buf   (rd_data),
    .done_flag(done_flag)
  );

  spi_tgt_txpath #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .shift    (shift),
    .byte_done(byte_done),
    .bit_idle (bit_idle),
    .tx_bit   (tx_bit)
  );

  assign miso_pin = active & tx_bit;

endmodule

// File: rtl/spi_target_chk.sv
module spi_target_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              clr_stb,
  input logic              miso_pin,
  input logic              done_flag,
  input logic [DATA_W-1:0] rd_data,
  input logic              byte_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sel_idle
);

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_flag);

  // R1
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_flag && !byte_done) |=> !done_flag);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_stb) |=> done_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !byte_done) |=> !done_flag);

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rd_data));

  // R9
  off_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !miso_pin);

  // R9
  off_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bit_cnt == '0));

  // R6
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_idle |=> $stable(bit_cnt));

endmodule

bind spi_target_port spi_target_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .clr_stb  (clr_stb),
  .miso_pin (miso_pin),
  .done_flag(done_flag),
  .rd_data  (rd_data),
  .byte_done(byte_done),
  .bit_cnt  (bit_cnt),
  .sel_idle (sel_idle)
);

// File: tb/test_spi_target_port.sv
module test_spi_target_port;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n, en, sck_pin, mosi_pin, sel_n_pin, wr_stb, clr_stb;
  logic [1:0] mode;
  logic [7:0] wr_data;
  logic       miso_pin, done_flag;
  logic [7:0] rd_data;

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 1'b0;

  logic [7:0] miso_cap;
  logic [7:0] m_hold, m_sh;
  bit         m_full, m_loaded;

  always #10 clk = ~clk;

  spi_target_port i_spi_target_port (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .sck_pin(sck_pin), .mosi_pin(mosi_pin), .sel_n_pin(sel_n_pin),
    .miso_pin(miso_pin), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .done_flag(done_flag), .clr_stb(clr_stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench view of the transmit side, applied only at byte boundaries.
  function automatic logic [7:0] model_start();
    return m_loaded ? m_sh : 8'h00;
  endfunction

  task automatic model_write(input logic [7:0] d);
    m_hold = d;
    m_full = 1'b1;
    if (!m_loaded) begin
      m_sh = m_hold; m_loaded = 1'b1; m_full = 1'b0;
    end
  endtask

  task automatic model_end();
    if (m_full) begin
      m_sh = m_hold; m_loaded = 1'b1; m_full = 1'b0;
    end else begin
      m_loaded = 1'b0;
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1;
    tick(1);
    wr_stb = 1'b0;
    tick(3);
  endtask

  task automatic clear_flag();
    clr_stb = 1'b1;
    tick(1);
    clr_stb = 1'b0;
    tick(2);
  endtask

  // Mode 0 controller: set MOSI, wait, capture MISO, raise SCK, wait, lower SCK.
  task automatic send_bits(input logic [7:0] b, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      mosi_pin = b[7-i];
      tick(HALF);
      miso_cap[7-i] = miso_pin;
      sck_pin = 1'b1;
      tick(HALF);
      sck_pin = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic xfer(input logic [7:0] b);
    miso_cap = 8'h00;
    send_bits(b, 0, 8);
  endtask

  task automatic framed(input logic [7:0] b);
    sel_n_pin = 1'b0;
    tick(4);
    xfer(b);
    tick(4);
    sel_n_pin = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, rx, exp_tx;
    int nw;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; mode = 2'b01; sck_pin = 1'b0; mosi_pin = 1'b0;
    sel_n_pin = 1'b1; wr_stb = 1'b0; wr_data = 8'h00; clr_stb = 1'b0;
    m_full = 1'b0; m_loaded = 1'b0; m_hold = 8'h00; m_sh = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check("R11 rd_data after reset", rd_data, 8'h00);
    check("R11 done_flag after reset", done_flag, 1'b0);
    check("R11 miso after reset", miso_pin, 1'b0);

    // First byte with empty holding register.
    en = 1'b1;
    tick(4);
    framed(8'hA5);
    check("R5 R11 zeros sent from empty", miso_cap, 8'h00);
    check("R1 received byte", rd_data, 8'hA5);
    check("R1 flag set", done_flag, 1'b1);
    tick(10);
    check("R10 flag held", done_flag, 1'b1);
    clear_flag();
    check("R10 flag cleared", done_flag, 1'b0);
    check("R10 rd_data kept after clear", rd_data, 8'hA5);

    // Immediate load, select gating of MISO.
    host_write(8'hC3);
    check("R6 miso low while deselected", miso_pin, 1'b0);
    sel_n_pin = 1'b0;
    tick(4);
    check("R3 loaded bit7 on miso", miso_pin, 1'b1);
    xfer(8'h11);
    tick(4);
    sel_n_pin = 1'b1;
    tick(4);
    check("R2 transmit order", miso_cap, 8'hC3);
    check("R1 second byte", rd_data, 8'h11);

    // Holding register overwrite and handover.
    host_write(8'h5A);
    host_write(8'h81);
    host_write(8'h7E);
    framed(8'h01);
    check("R4 first of burst", miso_cap, 8'h5A);
    framed(8'h02);
    check("R4 overwritten buffer", miso_cap, 8'h7E);
    framed(8'h03);
    check("R5 zeros after drain", miso_cap, 8'h00);

    // Write in the middle of a zero byte waits for the byte end.
    sel_n_pin = 1'b0;
    tick(4);
    miso_cap = 8'h00;
    send_bits(8'h12, 0, 4);
    host_write(8'h99);
    send_bits(8'h12, 4, 4);
    tick(4);
    sel_n_pin = 1'b1;
    tick(4);
    check("R4 mid-byte write not sent early", miso_cap, 8'h00);
    check("R1 split byte received", rd_data, 8'h12);
    framed(8'h21);
    check("R4 mid-byte write sent next", miso_cap, 8'h99);
    clear_flag();

    // SCK with select high is ignored.
    send_bits(8'hFF, 0, 8);
    tick(4);
    check("R6 no flag while deselected", done_flag, 1'b0);
    check("R6 rd_data kept while deselected", rd_data, 8'h21);
    check("R6 miso low while deselected", miso_cap, 8'h00);

    // Select fall discards a partial byte.
    sel_n_pin = 1'b0;
    tick(4);
    send_bits(8'hE0, 0, 3);
    sel_n_pin = 1'b1;
    tick(4);
    framed(8'h0F);
    check("R7 partial byte discarded", rd_data, 8'h0F);
    clear_flag();

    // Three-wire operation.
    mode = 2'b00;
    sel_n_pin = 1'b1;
    tick(4);
    xfer(8'h6D);
    tick(4);
    check("R8 three-wire byte with select high", rd_data, 8'h6D);
    check("R8 three-wire flag", done_flag, 1'b1);
    clear_flag();
    send_bits(8'hA0, 0, 3);
    check("R8 no flag after three bits", done_flag, 1'b0);
    sel_n_pin = 1'b0;
    tick(4);
    sel_n_pin = 1'b1;
    tick(4);
    send_bits(8'h1F, 3, 5);
    tick(4);
    check("R8 select toggle keeps count", rd_data, 8'hBF);
    check("R8 flag after straddled byte", done_flag, 1'b1);
    clear_flag();

    // Enable low: silent, ignores SCK, realigns the count.
    en = 1'b0;
    tick(2);
    host_write(8'h80);
    check("R9 miso low while disabled", miso_pin, 1'b0);
    send_bits(8'hFF, 0, 8);
    check("R9 no flag while disabled", done_flag, 1'b0);
    check("R9 rd_data kept while disabled", rd_data, 8'hBF);
    en = 1'b1;
    tick(4);
    check("R3 R9 loaded byte visible after enable", miso_pin, 1'b1);
    xfer(8'h44);
    tick(4);
    check("R9 byte sent after enable", miso_cap, 8'h80);
    check("R9 byte received after enable", rd_data, 8'h44);
    clear_flag();
    send_bits(8'hE0, 0, 3);
    en = 1'b0;
    tick(4);
    en = 1'b1;
    tick(4);
    xfer(8'h33);
    tick(4);
    check("R9 enable toggle realigns count", rd_data, 8'h33);
    clear_flag();

    // Random four-wire traffic against the bench model.
    mode = 2'b01;
    m_full = 1'b0; m_loaded = 1'b0;
    tick(4);
    for (int k = 0; k < 24; k++) begin
      nw = $urandom_range(0, 2);
      for (int w = 0; w < nw; w++) begin
        d = 8'($urandom);
        host_write(d);
        model_write(d);
      end
      rx = 8'($urandom);
      exp_tx = model_start();
      framed(rx);
      model_end();
      check("R2 R4 random transmit", miso_cap, exp_tx);
      check("R1 random receive", rd_data, rx);
      check("R1 random flag", done_flag, 1'b1);
      clear_flag();
      check("R10 random clear", done_flag, 1'b0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule